// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Unit

This block keeps eight hardware lock tokens that two processor ports, left and right, share. Each port has an active-low semaphore select, an active-low output enable, an active-low write strobe, an address and a 9-bit data bus. All of them are sampled on one common clock. A port asks for a token by writing a zero and gives it back by writing a one. Each side has a request latch for every token. An arbiter decides from these latches who owns each token.

A request that is refused stays in its latch. When the owner releases the token, it moves straight to the waiting side, and that side does not have to try again. A read returns the flag as seen from the reading side, copied onto every data bit. Once the read has captured its value, that value stays fixed for as long as the read lasts. A write from the other port cannot change it during the read.

Top module: `dual_sem_unit`

## Requirements
- R1: There are eight independent tokens. Address bits [2:0] select the token, and every higher address bit is ignored.
- R2: A synchronous reset sets all request latches to one. After reset all tokens are free and both read outputs are zero.
- R3: A port writes 0 to a free token and becomes its owner. Its reads of that token then return 9'h000, and reads from the other port return 9'h1FF.
- R4: A write of 1 from the side that does not own the token, with no request pending from that side, leaves ownership unchanged.
- R5: A 0 written by the non-owner is held as pending. When the owner writes 1, ownership passes to the waiting side in that same clock, and that side then reads 9'h000.
- R6: The owner writes 1 while no request is pending on the other side. The token becomes free, and both ports read 9'h1FF.
- R7: Both ports request the same free token in the same cycle. Exactly one side wins, and by a fixed rule that side is the left port.
- R8: A write uses only data bit 0 (0 = request, 1 = release or withdraw). Data bits [8:1] have no effect.
- R9: A read is active in a cycle when select = 0, output enable = 0 and write strobe = 1. On the first active edge the output register loads the replicated flag, taken from the state before that edge. The value then stays unchanged until the read becomes inactive.
- R10: On an edge where the read is not active, the read output becomes zero. Nothing is written while the port's select is high.
- R11: A pending requester can withdraw its request by writing 1. After that, a release by the owner leaves the token free.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock |
| rst | input | 1 | Synchronous reset, active high |
| lSemN | input | 1 | Left semaphore select, active low |
| lOeN | input | 1 | Left output enable, active low |
| lWeN | input | 1 | Left write strobe, active low |
| lAddr | input | ADDR_W | Left address; only the low 3 bits are used |
| lWrData | input | DATA_W | Left write data; only bit 0 is used |
| lRdData | output | DATA_W | Left read data, held for the whole read |
| rSemN | input | 1 | Right semaphore select, active low |
| rOeN | input | 1 | Right output enable, active low |
| rWeN | input | 1 | Right write strobe, active low |
| rAddr | input | ADDR_W | Right address; only the low 3 bits are used |
| rWrData | input | DATA_W | Right write data; only bit 0 is used |
| rRdData | output | DATA_W | Right read data, held for the whole read |

## Verification
The bench checks that a release by the owner hands the token to a pending requester in the same clock. A design that drops queued requests would leave the token free instead, and the waiting side would read all ones. The bench drives a same-cycle tie and checks that the loser's request stays queued, so that a later release passes the token to it. It checks that a read in progress stays frozen while the other port changes the owner, and that a design which tracks the live flag would show the new owner partway through the read. It also sends stray upper address bits, stray high data bits, writes with select high, and a withdrawn request. Each of these catches a decoder or latch update that is wrongly wide.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  // Strobes the port decoder hands to the datapath
  typedef struct packed {
    logic wr;     // write cycle this clock
    logic wrVal;  // data bit 0 of the write
    logic rdAct;  // read active this clock
  } portStrobe_t;
endpackage

// File: rtl/sem_ctrl.sv
module sem_ctrl
  import sem_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 9,
  parameter int IDX_W  = 3
) (
  input  logic              semN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output portStrobe_t       stb,
  output logic [IDX_W-1:0]  idx
);
  // Upper address and data bits do not take part in token access
  logic unusedBits;
  assign unusedBits = ^{addr[ADDR_W-1:IDX_W], wrData[DATA_W-1:1]};

  always_comb begin
    idx       = addr[IDX_W-1:0];
    stb.wr    = !semN && !weN;
    stb.wrVal = wrData[0];
    stb.rdAct = !semN && !oeN && weN;
  end
endmodule

// File: rtl/sem_datapath.sv
module sem_datapath
  import sem_pkg::*;
#(
  parameter int NUM_SEM = 8,
  parameter int IDX_W   = 3,
  parameter int DATA_W  = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  portStrobe_t       lStb,
  input  logic [IDX_W-1:0]  lIdx,
  input  portStrobe_t       rStb,
  input  logic [IDX_W-1:0]  rIdx,
  output logic [DATA_W-1:0] lRdData,
  output logic [DATA_W-1:0] rRdData
);
  // Request latches: 0 = request held, 1 = idle
  logic [NUM_SEM-1:0] reqL, reqR, nxtReqL, nxtReqR;
  owner_e owner  [NUM_SEM];
  owner_e nxtOwn [NUM_SEM];
  logic wasActL, wasActR;

  always_comb begin
    for (int s = 0; s < NUM_SEM; s++) begin
      nxtReqL[s] = (lStb.wr && lIdx == IDX_W'(s)) ? lStb.wrVal : reqL[s];
      nxtReqR[s] = (rStb.wr && rIdx == IDX_W'(s)) ? rStb.wrVal : reqR[s];
      nxtOwn[s]  = owner[s];
      case (owner[s])
        OWN_NONE:
          if (!nxtReqL[s])      nxtOwn[s] = OWN_LEFT;   // left wins ties
          else if (!nxtReqR[s]) nxtOwn[s] = OWN_RIGHT;
        OWN_LEFT:
          if (nxtReqL[s])       nxtOwn[s] = nxtReqR[s] ? OWN_NONE : OWN_RIGHT;
        OWN_RIGHT:
          if (nxtReqR[s])       nxtOwn[s] = nxtReqL[s] ? OWN_NONE : OWN_LEFT;
        default:                nxtOwn[s] = OWN_NONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reqL <= '1;
      reqR <= '1;
      for (int s = 0; s < NUM_SEM; s++) owner[s] <= OWN_NONE;
    end else begin
      reqL <= nxtReqL;
      reqR <= nxtReqR;
      for (int s = 0; s < NUM_SEM; s++) owner[s] <= nxtOwn[s];
    end
  end

  // Read capture: load on the first active edge, hold while active
  always_ff @(posedge clk) begin
    if (rst) begin
      wasActL <= 1'b0;
      wasActR <= 1'b0;
      lRdData <= '0;
      rRdData <= '0;
    end else begin
      wasActL <= lStb.rdAct;
      wasActR <= rStb.rdAct;
      if (!lStb.rdAct)   lRdData <= '0;
      else if (!wasActL) lRdData <= {DATA_W{owner[lIdx] != OWN_LEFT}};
      if (!rStb.rdAct)   rRdData <= '0;
      else if (!wasActR) rRdData <= {DATA_W{owner[rIdx] != OWN_RIGHT}};
    end
  end

  a_r3_claim_free: assert property (@(posedge clk) disable iff (rst)
    (owner[lIdx] == OWN_NONE && lStb.wr && !lStb.wrVal)
    |=> owner[$past(lIdx)] == OWN_LEFT);

  a_r4_nonowner_release: assert property (@(posedge clk) disable iff (rst)
    (owner[rIdx] == OWN_LEFT && rStb.wr && rStb.wrVal && !(lStb.wr && lIdx == rIdx))
    |=> owner[$past(rIdx)] == OWN_LEFT);

  a_r5_handoff: assert property (@(posedge clk) disable iff (rst)
    (owner[lIdx] == OWN_LEFT && lStb.wr && lStb.wrVal && !reqR[lIdx]
     && !(rStb.wr && rIdx == lIdx))
    |=> owner[$past(lIdx)] == OWN_RIGHT);

  a_r7_tie_left: assert property (@(posedge clk) disable iff (rst)
    (lStb.wr && !lStb.wrVal && rStb.wr && !rStb.wrVal && lIdx == rIdx
     && owner[lIdx] == OWN_NONE)
    |=> owner[$past(lIdx)] == OWN_LEFT);

  a_r9_hold_left: assert property (@(posedge clk) disable iff (rst)
    (lStb.rdAct && $past(lStb.rdAct)) |=> $stable(lRdData));

  a_r9_hold_right: assert property (@(posedge clk) disable iff (rst)
    (rStb.rdAct && $past(rStb.rdAct)) |=> $stable(rRdData));

  a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
    (!lStb.rdAct && !rStb.rdAct) |=> (lRdData == '0 && rRdData == '0));
endmodule

// File: rtl/dual_sem_unit.sv
module dual_sem_unit
  import sem_pkg::*;
#(
  parameter int NUM_SEM = 8,
  parameter int ADDR_W  = 14,
  parameter int DATA_W  = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lSemN,
  input  logic              lOeN,
  input  logic              lWeN,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic [DATA_W-1:0] lWrData,
  output logic [DATA_W-1:0] lRdData,
  input  logic              rSemN,
  input  logic              rOeN,
  input  logic              rWeN,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic [DATA_W-1:0] rWrData,
  output logic [DATA_W-1:0] rRdData
);
  localparam int IDX_W = $clog2(NUM_SEM);

  portStrobe_t lStb, rStb;
  logic [IDX_W-1:0] lIdx, rIdx;

  sem_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) lCtrl_i (
    .semN(lSemN), .oeN(lOeN), .weN(lWeN), .addr(lAddr), .wrData(lWrData),
    .stb(lStb), .idx(lIdx)
  );

  sem_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) rCtrl_i (
    .semN(rSemN), .oeN(rOeN), .weN(rWeN), .addr(rAddr), .wrData(rWrData),
    .stb(rStb), .idx(rIdx)
  );

  sem_datapath #(.NUM_SEM(NUM_SEM), .IDX_W(IDX_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rst(rst),
    .lStb(lStb), .lIdx(lIdx), .rStb(rStb), .rIdx(rIdx),
    .lRdData(lRdData), .rRdData(rRdData)
  );
endmodule

// File: tb/dual_sem_unit_tb_top.sv
`timescale 1ns/1ps
module dual_sem_unit_tb_top;
  localparam int NS = 8;
  localparam int AW = 14;
  localparam int DW = 9;
  localparam logic [DW-1:0] ONES = '1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst;
  logic lSemN, lOeN, lWeN, rSemN, rOeN, rWeN;
  logic [AW-1:0] lAddr, rAddr;
  logic [DW-1:0] lWrData, rWrData, lRdData, rRdData;

  dual_sem_unit dut_i (
    .clk(clk), .rst(rst),
    .lSemN(lSemN), .lOeN(lOeN), .lWeN(lWeN), .lAddr(lAddr), .lWrData(lWrData), .lRdData(lRdData),
    .rSemN(rSemN), .rOeN(rOeN), .rWeN(rWeN), .rAddr(rAddr), .rWrData(rWrData), .rRdData(rRdData)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: 0 free, 1 left owns, 2 right owns
  int mOwn[NS];
  bit mReqL[NS], mReqR[NS];
  logic [DW-1:0] mRdL = '0, mRdR = '0;
  bit mWasL, mWasR;

  always @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NS; s++) begin mOwn[s] = 0; mReqL[s] = 1; mReqR[s] = 1; end
      mRdL = '0; mRdR = '0; mWasL = 0; mWasR = 0;
    end else begin
      bit actL, actR;
      int il, ir;
      actL = !lSemN && !lOeN && lWeN;
      actR = !rSemN && !rOeN && rWeN;
      il = int'(lAddr[2:0]);
      ir = int'(rAddr[2:0]);
      if (!actL) mRdL = '0; else if (!mWasL) mRdL = (mOwn[il] == 1) ? '0 : ONES;
      if (!actR) mRdR = '0; else if (!mWasR) mRdR = (mOwn[ir] == 2) ? '0 : ONES;
      mWasL = actL; mWasR = actR;
      if (!lSemN && !lWeN) mReqL[il] = lWrData[0];
      if (!rSemN && !rWeN) mReqR[ir] = rWrData[0];
      for (int s = 0; s < NS; s++) begin
        if (mOwn[s] == 0) begin
          if (!mReqL[s]) mOwn[s] = 1; else if (!mReqR[s]) mOwn[s] = 2;
        end else if (mOwn[s] == 1) begin
          if (mReqL[s]) mOwn[s] = mReqR[s] ? 0 : 2;
        end else begin
          if (mReqR[s]) mOwn[s] = mReqL[s] ? 0 : 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R9 model left", lRdData, mRdL);
      check("R9 model right", rRdData, mRdR);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle();
    lSemN = 1; lOeN = 1; lWeN = 1; lAddr = '0; lWrData = '1;
    rSemN = 1; rOeN = 1; rWeN = 1; rAddr = '0; rWrData = '1;
  endtask

  task automatic wr(bit right, int idx, logic [DW-1:0] d, logic [AW-1:0] hi = '0);
    if (right) begin rSemN = 0; rWeN = 0; rOeN = 1; rAddr = hi | AW'(idx); rWrData = d; end
    else       begin lSemN = 0; lWeN = 0; lOeN = 1; lAddr = hi | AW'(idx); lWrData = d; end
    tick(1);
    if (right) begin rSemN = 1; rWeN = 1; end
    else       begin lSemN = 1; lWeN = 1; end
  endtask

  task automatic rdStart(bit right, int idx);
    if (right) begin rSemN = 0; rOeN = 0; rWeN = 1; rAddr = AW'(idx); end
    else       begin lSemN = 0; lOeN = 0; lWeN = 1; lAddr = AW'(idx); end
    tick(1);
  endtask

  task automatic rdEnd(bit right);
    if (right) begin rSemN = 1; rOeN = 1; end
    else       begin lSemN = 1; lOeN = 1; end
    tick(1);
  endtask

  task automatic readChk(bit right, int idx, logic [DW-1:0] exp, string req);
    rdStart(right, idx);
    check(req, right ? rRdData : lRdData, exp);
    rdEnd(right);
  endtask

  initial begin
    #(5ns * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    rst = 1;
    tick(3);
    rst = 0;
    tick(1);
    // R2: reset state
    check("R2 left idle out", lRdData, '0);
    check("R2 right idle out", rRdData, '0);
    for (int s = 0; s < NS; s++) begin
      readChk(0, s, ONES, "R2 free left");
      readChk(1, s, ONES, "R2 free right");
    end

    // R1/R3: claim with stray high address bits
    wr(0, 3, '0, 14'h3FF8);
    readChk(0, 3, '0, "R1 left owns token 3");
    readChk(1, 3, ONES, "R3 right sees taken");
    readChk(0, 2, ONES, "R1 neighbour untouched");

    // R4: non-owner release has no effect
    wr(1, 3, ONES);
    readChk(0, 3, '0, "R4 still left owned");

    // R5: queued request hands over on release
    wr(1, 3, '0);
    readChk(1, 3, ONES, "R5 refused request");
    wr(0, 3, ONES);
    readChk(1, 3, '0, "R5 right now owns");
    readChk(0, 3, ONES, "R5 left lost token");

    // R6: release with nothing pending
    wr(1, 3, ONES);
    readChk(0, 3, ONES, "R6 free left");
    readChk(1, 3, ONES, "R6 free right");

    // R7: same-cycle tie
    lSemN = 0; lWeN = 0; lAddr = 5; lWrData = '0;
    rSemN = 0; rWeN = 0; rAddr = 5; rWrData = '0;
    tick(1);
    idle();
    readChk(0, 5, '0, "R7 left wins tie");
    readChk(1, 5, ONES, "R7 right loses tie");
    wr(0, 5, ONES);
    readChk(1, 5, '0, "R5 loser queued then owns");
    wr(1, 5, ONES);

    // R11: withdraw a pending request
    wr(0, 6, '0);
    wr(1, 6, '0);
    wr(1, 6, ONES);
    wr(0, 6, ONES);
    readChk(1, 6, ONES, "R11 withdrawn right");
    readChk(0, 6, ONES, "R11 withdrawn left");

    // R8: only bit 0 matters
    wr(0, 1, 9'h1FE);
    readChk(0, 1, '0, "R8 claim by bit0");
    wr(0, 1, 9'h001);
    readChk(0, 1, ONES, "R8 release by bit0");

    // R9: read frozen while other side changes owner
    wr(0, 2, '0);
    wr(1, 2, '0);
    rdStart(1, 2);
    check("R9 right read start", rRdData, ONES);
    wr(0, 2, ONES);
    tick(1);
    check("R9 right read frozen", rRdData, ONES);
    rdEnd(1);
    readChk(1, 2, '0, "R9 re-read shows new owner");
    wr(1, 2, ONES);

    // R10: select high blocks writes, output zero
    lSemN = 1; lWeN = 0; lOeN = 0; lAddr = 4; lWrData = '0;
    tick(1);
    check("R10 deselected out zero", lRdData, '0);
    idle();
    readChk(0, 4, ONES, "R10 write ignored left");
    readChk(1, 4, ONES, "R10 write ignored right");

    tick(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule